// File: doc/BRIEF.md
# Bus Role and Enable Sequencer

This block decides when a serial-bus host controller is allowed to touch the bus and in which role. It comes out of reset passive: the PHY enable is low, no role is selected and the command queues are neither enabled nor running. Software programs three small registers through a plain write port. These registers hold a control word with a bus-enable bit and a transfer-mode field, a role word that selects and configures the role, and a queue word with separate enable and run bits.

The PHY is enabled once bus enable is set and the selected role is fully configured. An active-controller role needs nothing more. A standby (target) role also needs its standby-init field, its target-transaction enable and a valid static address. The sequencer then holds for a fixed queue-initialization period before it reports that it is initialized. Only after that does it pass the queue enable through. It starts the queues only when both the enable bit and the run bit are set. Dropping bus enable, or changing the resolved role, returns the block to the quiescent state on the next cycle.

Top module: `busrole_seq`

## Requirements
- R1: After reset, `phy_en`, `q_enable`, `q_run` and `init_done` are 0 and `role` is 0 (none).
- R2: The control register is at address 0. Bit 0 is bus enable and bits [5:4] are the transfer mode. A control write whose mode field is not 1 is ignored entirely, so bus enable keeps its previous value.
- R3: The role register is at address 2, and its bits [1:0] select the role: 1 is active, 2 is standby, and 0 or 3 is disabled. With bus enable set and the active role selected, `phy_en` is 1 and `role` reads 1 on the cycle after the enabling register write takes effect.
- R4: The standby role resolves only when all of the following are set in the role register: bits [5:4] equal 2, bit 8 (target transactions) is 1 and bit 23 (static address valid) is 1. If any of them is missing, or the role is 0 or 3, `phy_en` stays 0 and `role` reads 0. When the standby role is entered, `role` reads 2. Bits [22:16] appear on `tgt_static_addr`.
- R5: `init_done` rises exactly INIT_CYCLES clock cycles after `phy_en` rises, and it is 0 whenever `phy_en` is 0.
- R6: The queue register is at address 1, with bit 0 as enable and bit 1 as run. Once `init_done` is 1, `q_enable` follows the enable bit one cycle after the write, and `q_run` is 1 only when both bits are set.
- R7: Setting the run bit while the enable bit is clear does not start the queues: `q_run` stays 0.
- R8: One cycle after bus enable is cleared, `phy_en`, `role`, `q_enable`, `q_run` and `init_done` are all 0. This applies during initialization as well as after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | DATA_W | Register write data |
| phy_en | output | 1 | Enable to the PHY and bus engine |
| role | output | 2 | Current role: 0 none, 1 active, 2 standby |
| q_enable | output | 1 | Queue enable |
| q_run | output | 1 | Queue run |
| init_done | output | 1 | Queue initialization finished |
| tgt_static_addr | output | 7 | Configured static address |

## Verification
The bench sweeps every role code against every combination of the three standby prerequisites. A resolver that skipped one prerequisite would bring up the PHY in a half-configured standby role. For each configuration that comes up, the bench counts the cycles to `init_done`, so an off-by-one in the initialization counter shows up directly. It then steps through all four queue bit patterns, which catches a design that starts the queues on the run bit alone. It also writes bad transfer-mode values while the bus is off and while it is on, and drops bus enable in the middle of initialization. These catch a design that latches enable regardless of mode, or one that leaves `init_done` or `q_run` set after the bus is disabled.

// File: rtl/busrole_pkg.sv
package busrole_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE    = 2'd0,
    ROLE_ACTIVE  = 2'd1,
    ROLE_STANDBY = 2'd2
  } role_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_INIT,
    ST_IDLE,
    ST_RUN
  } seq_state_e;

  localparam int CTRL_ADDR  = 0;
  localparam int QUEUE_ADDR = 1;
  localparam int ROLE_ADDR  = 2;

  localparam logic [1:0] XFER_MODE_OK  = 2'd1;
  localparam logic [1:0] STBY_INIT_OK  = 2'd2;

endpackage

// File: rtl/busrole_regs.sv
module busrole_regs
  import busrole_pkg::*;
#(
  parameter int         ADDR_W     = 4,
  parameter int         DATA_W     = 32,
  parameter logic [1:0] RESET_ROLE = 2'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bus_en,
  output logic              q_en_bit,
  output logic              q_run_bit,
  output logic [1:0]        role_sel,
  output logic [1:0]        stby_init,
  output logic              tgt_xact,
  output logic              addr_valid,
  output logic [6:0]        static_addr
);

  logic hit_ctrl, hit_queue, hit_role, mode_good;
  logic unused_wdata;

  assign hit_ctrl     = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign hit_queue    = wr_en && (wr_addr == ADDR_W'(QUEUE_ADDR));
  assign hit_role     = wr_en && (wr_addr == ADDR_W'(ROLE_ADDR));
  assign mode_good    = (wr_data[5:4] == XFER_MODE_OK);
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_en      <= 1'b0;
      q_en_bit    <= 1'b0;
      q_run_bit   <= 1'b0;
      role_sel    <= RESET_ROLE;
      stby_init   <= 2'd0;
      tgt_xact    <= 1'b0;
      addr_valid  <= 1'b0;
      static_addr <= 7'd0;
    end else begin
      if (hit_ctrl && mode_good) bus_en <= wr_data[0];
      if (hit_queue) begin
        q_en_bit  <= wr_data[0];
        q_run_bit <= wr_data[1];
      end
      if (hit_role) begin
        role_sel    <= wr_data[1:0];
        stby_init   <= wr_data[5:4];
        tgt_xact    <= wr_data[8];
        static_addr <= wr_data[22:16];
        addr_valid  <= wr_data[23];
      end
    end
  end

  // R2: a control write with an unsupported transfer mode leaves bus enable alone
  p_bad_mode_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_ctrl && !mode_good) |=> $stable(bus_en));

endmodule

// File: rtl/busrole_resolve.sv
module busrole_resolve
  import busrole_pkg::*;
(
  input  logic       bus_en,
  input  logic [1:0] role_sel,
  input  logic [1:0] stby_init,
  input  logic       tgt_xact,
  input  logic       addr_valid,
  output role_e      tgt_role
);

  logic stby_ready;
  assign stby_ready = (stby_init == STBY_INIT_OK) && tgt_xact && addr_valid;

  always_comb begin
    tgt_role = ROLE_NONE;
    if (bus_en) begin
      case (role_sel)
        2'd1:    tgt_role = ROLE_ACTIVE;
        2'd2:    tgt_role = stby_ready ? ROLE_STANDBY : ROLE_NONE;
        default: tgt_role = ROLE_NONE;
      endcase
    end
  end

endmodule

// File: rtl/busrole_init_timer.sv
module busrole_init_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start)         cnt <= CW'(CYCLES - 1);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/busrole_seq.sv
module busrole_seq
  import busrole_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 32,
  parameter int         INIT_CYCLES = 8,
  parameter logic [1:0] RESET_ROLE  = 2'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              phy_en,
  output logic [1:0]        role,
  output logic              q_enable,
  output logic              q_run,
  output logic              init_done,
  output logic [6:0]        tgt_static_addr
);

  logic       bus_en_r, q_en_r, q_run_r, tgt_xact_r, addr_valid_r;
  logic [1:0] role_sel_r, stby_init_r;
  role_e      tgt_role, cur_role;
  seq_state_e st, nxt;
  logic       timer_start, timer_expired, role_change, q_both;

  busrole_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_ROLE(RESET_ROLE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_en(bus_en_r), .q_en_bit(q_en_r), .q_run_bit(q_run_r),
    .role_sel(role_sel_r), .stby_init(stby_init_r), .tgt_xact(tgt_xact_r),
    .addr_valid(addr_valid_r), .static_addr(tgt_static_addr)
  );

  busrole_resolve u_resolve (
    .bus_en(bus_en_r), .role_sel(role_sel_r), .stby_init(stby_init_r),
    .tgt_xact(tgt_xact_r), .addr_valid(addr_valid_r), .tgt_role(tgt_role)
  );

  busrole_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(timer_start), .expired(timer_expired)
  );

  assign role_change = (tgt_role != cur_role);
  assign q_both      = q_en_r && q_run_r;
  assign timer_start = (st == ST_OFF) && (nxt == ST_INIT);

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:  if (tgt_role != ROLE_NONE) nxt = ST_INIT;
      ST_INIT: if (role_change) nxt = ST_OFF;
               else if (timer_expired) nxt = ST_IDLE;
      ST_IDLE: if (role_change) nxt = ST_OFF;
               else if (q_both) nxt = ST_RUN;
      ST_RUN:  if (role_change) nxt = ST_OFF;
               else if (!q_both) nxt = ST_IDLE;
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OFF;
      cur_role  <= ROLE_NONE;
      phy_en    <= 1'b0;
      q_enable  <= 1'b0;
      q_run     <= 1'b0;
      init_done <= 1'b0;
    end else begin
      st        <= nxt;
      if (nxt == ST_OFF)     cur_role <= ROLE_NONE;
      else if (st == ST_OFF) cur_role <= tgt_role;
      phy_en    <= (nxt != ST_OFF);
      q_enable  <= ((nxt == ST_IDLE) || (nxt == ST_RUN)) && q_en_r;
      q_run     <= (nxt == ST_RUN);
      init_done <= (nxt == ST_IDLE) || (nxt == ST_RUN);
    end
  end

  assign role = cur_role;

  // R1 / R3: no role is reported while the PHY is off
  p_role_none_off_r3: assert property (@(posedge clk) disable iff (rst)
    !phy_en |-> (role == 2'd0));

  // R5: initialization-done never outlives the PHY enable
  p_done_needs_phy_r5: assert property (@(posedge clk) disable iff (rst)
    !phy_en |-> !init_done);

  // R6: queues run only after initialization completed
  p_run_after_init_r6: assert property (@(posedge clk) disable iff (rst)
    q_run |-> init_done);

  // R7: running queues are always enabled queues
  p_run_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    q_run |-> q_enable);

  // R8: bus enable low forces quiescence on the next cycle
  p_drop_quiesce_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_en_r |=> (!phy_en && !q_run && !init_done));

endmodule

// File: tb/busrole_seq_tb.sv
module busrole_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INIT_N     = 5;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              phy_en, q_enable, q_run, init_done;
  logic [1:0]        role;
  logic [6:0]        tgt_static_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busrole_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYCLES(INIT_N)
  ) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phy_en(phy_en), .role(role), .q_enable(q_enable), .q_run(q_run),
    .init_done(init_done), .tgt_static_addr(tgt_static_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input int mode, input bit en);
    return (32'(mode) << 4) | 32'(en);
  endfunction

  task automatic all_off(input string req);
    chk({req, " phy_en"}, phy_en, 0);
    chk({req, " role"}, role, 0);
    chk({req, " q_enable"}, q_enable, 0);
    chk({req, " q_run"}, q_run, 0);
    chk({req, " init_done"}, init_done, 0);
  endtask

  task automatic wait_init(input string req);
    int cnt = 0;
    while (!init_done && cnt < 4 * INIT_N + 4) begin
      @(negedge clk);
      cnt++;
    end
    chk(req, cnt, INIT_N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    all_off("R1 reset");

    // Sweep every role code against every standby prerequisite combination
    for (int rs = 0; rs < 4; rs++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        bit s_ok  = cfg[0];
        bit txe   = cfg[1];
        bit valid = cfg[2];
        int exp_role;
        logic [6:0] sa = 7'(7'h11 + rs * 8 + cfg);
        logic [31:0] rw;
        exp_role = (rs == 1) ? 1 : ((rs == 2 && s_ok && txe && valid) ? 2 : 0);
        rw = (32'(valid) << 23) | (32'(sa) << 16) | (32'(txe) << 8)
           | ((s_ok ? 32'd2 : 32'd1) << 4) | 32'(rs);
        wr(2, rw);
        chk("R4 static address", tgt_static_addr, sa);
        wr(0, ctrl_word(1, 1'b1));
        @(negedge clk);
        chk(exp_role == 2 ? "R4 phy_en" : "R3 phy_en", phy_en, exp_role != 0);
        chk(exp_role == 2 ? "R4 role" : "R3 role", role, exp_role);
        if (exp_role != 0) begin
          chk("R5 done low at enable", init_done, 0);
          wait_init("R5 init cycles");
          for (int qc = 0; qc < 4; qc++) begin
            wr(1, 32'(qc));
            @(negedge clk);
            chk("R6 q_enable", q_enable, qc & 1);
            chk(qc == 2 ? "R7 run without enable" : "R6 q_run", q_run, qc == 3);
          end
        end else begin
          repeat (2) @(negedge clk);
          chk("R4 stays off", phy_en, 0);
        end
        wr(0, ctrl_word(1, 1'b0));
        @(negedge clk);
        all_off("R8 disable");
        wr(1, 32'd0);
      end
    end

    // Transfer-mode rejection while off
    wr(2, 32'd1);
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        wr(0, ctrl_word(m, 1'b1));
        repeat (2) @(negedge clk);
        chk("R2 bad mode while off", phy_en, 0);
      end
    end

    // Transfer-mode rejection while on
    wr(0, ctrl_word(1, 1'b1));
    @(negedge clk);
    wait_init("R5 init cycles again");
    wr(0, ctrl_word(0, 1'b0));
    repeat (2) @(negedge clk);
    chk("R2 bad mode while on", phy_en, 1);
    chk("R2 done kept", init_done, 1);

    // Drop bus enable mid-initialization
    wr(0, ctrl_word(1, 1'b0));
    @(negedge clk);
    all_off("R8 after run");
    wr(0, ctrl_word(1, 1'b1));
    @(negedge clk);
    chk("R3 re-enable", phy_en, 1);
    wr(0, ctrl_word(1, 1'b0));
    @(negedge clk);
    all_off("R8 mid-init");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule